// File: doc/BRIEF.md
# Exponential Weight Annealing Schedule Generator

This block produces one global fixed-point scale factor for a recurrent binary optimisation network. The factor multiplies every synaptic weight at once, and the bias terms are left at full strength. A start pulse clears the scale to zero. On each epoch tick the scale then rises toward one. In exponential mode it follows the curve 1 − e^(−t/τ), built by a recurrence. In linear mode it climbs by a fixed step. The schedule is open-loop: the block takes no input from the network state or its energy.

The exponential curve needs no lookup table. Each tick adds the product of the remaining gap to full scale and a programmed rate α ≈ 1/τ. That product is rounded up, so the scale always reaches full scale exactly. A saturation flag reports when the scale is at full scale. An epoch counter reports how many ticks have passed since the last start.

Top module: `anneal_sched`

## Requirements
- R1: After reset the scale output, the epoch output and the saturation flag are all zero.
- R2: A cycle with `start_i` high makes the scale and the epoch count zero on the next cycle, whatever `tick_i` is in that cycle.
- R3: With `mode_i` = 0 (exponential), a tick without start sets scale to s + ceil((2^FRAC_W − s) × rate / 2^FRAC_W). Here s is the current scale and rate is `rate_i` read as an unsigned fraction in units of 2^−FRAC_W.
- R4: With `mode_i` = 1 (linear), a tick without start sets scale to min(2^FRAC_W, s + rate).
- R5: In a cycle with neither start nor tick, the scale and the epoch count keep their values.
- R6: The scale never exceeds full scale (2^FRAC_W). `sat_o` is 1 exactly when the scale equals full scale, and it stays 1 through further ticks.
- R7: Each tick without start raises the epoch count by one. The count stops at its maximum, 2^EPOCH_W − 1.
- R8: A tick with `rate_i` = 0 leaves the scale unchanged while the epoch count still advances.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Restart the schedule (clears scale and epoch) |
| tick_i | input | 1 | Epoch advance strobe |
| mode_i | input | 1 | 0 exponential, 1 linear |
| rate_i | input | FRAC_W | Per-epoch rate α (exponential) or step (linear), in units of 2^−FRAC_W |
| scale_o | output | FRAC_W+1 | Weight scale, full scale = 2^FRAC_W |
| sat_o | output | 1 | Scale has reached full scale |
| epoch_o | output | EPOCH_W | Epochs since last start, saturating |

## Verification
Two corners are hard to reach from the ports. The first is the last few exponential steps, where the rounded-up increment is a single LSB and must land exactly on full scale. The second is the epoch counter pinned at its maximum. The bench uses a narrow epoch counter and long unbroken runs of ticks so both saturations occur. It also uses a large rate so the exponential tail arrives within a few dozen epochs. It then interleaves restarts that coincide with ticks, idle gaps, mode changes and a zero rate.

// File: rtl/anneal_pkg.sv
package anneal_pkg;
    typedef enum logic {
        MODE_EXP = 1'b0,
        MODE_LIN = 1'b1
    } anneal_mode_e;
endpackage

// File: rtl/anneal_exp_step.sv
// One recurrence step: s + ceil((full - s) * rate), clamped to full scale.
module anneal_exp_step #(
    parameter int FRAC_W = 16
) (
    input  logic [FRAC_W:0]   scale_i,
    input  logic [FRAC_W-1:0] rate_i,
    output logic [FRAC_W:0]   next_o
);
    localparam int SW = FRAC_W + 1;
    localparam int PW = SW + FRAC_W;
    localparam logic [SW-1:0] FULL = {1'b1, {FRAC_W{1'b0}}};

    logic [SW-1:0] gap;
    logic [PW-1:0] prod;
    logic [PW:0]   rounded;
    logic [SW:0]   incr;
    logic [SW:0]   sum;

    always_comb begin
        gap     = FULL - scale_i;
        prod    = {{FRAC_W{1'b0}}, gap} * {{SW{1'b0}}, rate_i};
        rounded = {1'b0, prod} + {{(SW + 1){1'b0}}, {FRAC_W{1'b1}}};
        incr    = rounded[PW:FRAC_W];
        sum     = {1'b0, scale_i} + incr;
        next_o  = (sum > {1'b0, FULL}) ? FULL : sum[SW-1:0];
    end
endmodule

// File: rtl/anneal_lin_step.sv
// Linear ramp step, clamped to full scale.
module anneal_lin_step #(
    parameter int FRAC_W = 16
) (
    input  logic [FRAC_W:0]   scale_i,
    input  logic [FRAC_W-1:0] rate_i,
    output logic [FRAC_W:0]   next_o
);
    localparam int SW = FRAC_W + 1;
    localparam logic [SW-1:0] FULL = {1'b1, {FRAC_W{1'b0}}};

    logic [SW:0] sum;

    always_comb begin
        sum    = {1'b0, scale_i} + {2'b00, rate_i};
        next_o = (sum > {1'b0, FULL}) ? FULL : sum[SW-1:0];
    end
endmodule

// File: rtl/anneal_epoch_next.sv
// Saturating epoch increment.
module anneal_epoch_next #(
    parameter int EPOCH_W = 16
) (
    input  logic [EPOCH_W-1:0] epoch_i,
    output logic [EPOCH_W-1:0] next_o
);
    localparam logic [EPOCH_W-1:0] EMAX = {EPOCH_W{1'b1}};

    always_comb begin
        next_o = (epoch_i == EMAX) ? epoch_i : epoch_i + 1'b1;
    end
endmodule

// File: rtl/anneal_sched.sv
module anneal_sched #(
    parameter int FRAC_W  = 16,
    parameter int EPOCH_W = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start_i,
    input  logic               tick_i,
    input  logic               mode_i,
    input  logic [FRAC_W-1:0]  rate_i,
    output logic [FRAC_W:0]    scale_o,
    output logic               sat_o,
    output logic [EPOCH_W-1:0] epoch_o
);
    import anneal_pkg::*;

    localparam int SW = FRAC_W + 1;
    localparam logic [SW-1:0] FULL = {1'b1, {FRAC_W{1'b0}}};

    typedef struct packed {
        logic [SW-1:0]      scale;
        logic [EPOCH_W-1:0] epoch;
    } sched_t;

    sched_t st_d, st_q;
    logic [SW-1:0]      exp_next, lin_next;
    logic [EPOCH_W-1:0] epoch_next;
    anneal_mode_e       mode;

    assign mode = anneal_mode_e'(mode_i);

    anneal_exp_step #(.FRAC_W(FRAC_W)) u_exp (
        .scale_i(st_q.scale), .rate_i(rate_i), .next_o(exp_next)
    );
    anneal_lin_step #(.FRAC_W(FRAC_W)) u_lin (
        .scale_i(st_q.scale), .rate_i(rate_i), .next_o(lin_next)
    );
    anneal_epoch_next #(.EPOCH_W(EPOCH_W)) u_epoch (
        .epoch_i(st_q.epoch), .next_o(epoch_next)
    );

    always_comb begin
        st_d = st_q;
        if (start_i) begin
            st_d.scale = '0;
            st_d.epoch = '0;
        end else if (tick_i) begin
            st_d.scale = (mode == MODE_LIN) ? lin_next : exp_next;
            st_d.epoch = epoch_next;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign scale_o = st_q.scale;
    assign epoch_o = st_q.epoch;
    assign sat_o   = (st_q.scale == FULL);
endmodule

// File: rtl/anneal_sched_chk.sv
module anneal_sched_chk #(
    parameter int FRAC_W  = 16,
    parameter int EPOCH_W = 16
) (
    input logic               clk,
    input logic               rst_n,
    input logic               start_i,
    input logic               tick_i,
    input logic [FRAC_W-1:0]  rate_i,
    input logic [FRAC_W:0]    scale_o,
    input logic               sat_o,
    input logic [EPOCH_W-1:0] epoch_o
);
    localparam logic [FRAC_W:0]    FULL = {1'b1, {FRAC_W{1'b0}}};
    localparam logic [EPOCH_W-1:0] EMAX = {EPOCH_W{1'b1}};

    p_start_clears_r2: assert property (@(posedge clk) disable iff (!rst_n)
        start_i |=> (scale_o == '0 && epoch_o == '0));
    p_idle_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!start_i && !tick_i) |=> ($stable(scale_o) && $stable(epoch_o)));
    p_bound_r6: assert property (@(posedge clk) disable iff (!rst_n)
        scale_o <= FULL);
    p_sat_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (sat_o && !start_i) |=> sat_o);
    p_monotone_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_i && !start_i) |=> scale_o >= $past(scale_o));
    p_epoch_step_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_i && !start_i && epoch_o != EMAX) |=> epoch_o == $past(epoch_o) + 1'b1);
    p_epoch_cap_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_i && !start_i && epoch_o == EMAX) |=> epoch_o == EMAX);
    p_zero_rate_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_i && !start_i && rate_i == '0) |=> $stable(scale_o));
endmodule

bind anneal_sched anneal_sched_chk #(.FRAC_W(FRAC_W), .EPOCH_W(EPOCH_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .tick_i(tick_i),
    .rate_i(rate_i), .scale_o(scale_o), .sat_o(sat_o), .epoch_o(epoch_o)
);

// File: tb/anneal_sched_bench.sv
`timescale 1ns/1ps
module anneal_sched_bench;
    localparam int FW = 16;
    localparam int EW = 8;
    localparam longint FULLV = 64'd1 << FW;
    localparam longint EMAXV = (64'd1 << EW) - 1;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start_i = 1'b0, tick_i = 1'b0, mode_i = 1'b0;
    logic [FW-1:0] rate_i = '0;
    logic [FW:0] scale_o;
    logic sat_o;
    logic [EW-1:0] epoch_o;

    int total = 0, bad = 0;
    longint m_scale = 0, m_epoch = 0;
    string tag = "R1";

    always #5 clk = ~clk;

    anneal_sched #(.FRAC_W(FW), .EPOCH_W(EW)) u_anneal_sched (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .tick_i(tick_i),
        .mode_i(mode_i), .rate_i(rate_i), .scale_o(scale_o), .sat_o(sat_o),
        .epoch_o(epoch_o)
    );

    task automatic check_all();
        total++;
        if (longint'(scale_o) != m_scale || longint'(epoch_o) != m_epoch ||
            sat_o != (m_scale == FULLV)) begin
            bad++;
            $display("FAIL %s: scale=%0d epoch=%0d sat=%0d expected scale=%0d epoch=%0d sat=%0d",
                     tag, scale_o, epoch_o, sat_o, m_scale, m_epoch, m_scale == FULLV);
        end
    endtask

    // drive at negedge, advance model at posedge, compare at next negedge
    task automatic step(input logic st, input logic tk, input logic md,
                        input int rt, input string t);
        longint gap, inc;
        start_i = st; tick_i = tk; mode_i = md; rate_i = rt[FW-1:0];
        tag = t;
        @(posedge clk);
        if (st) begin
            m_scale = 0; m_epoch = 0;
        end else if (tk) begin
            if (md) begin
                m_scale = m_scale + rt;
            end else begin
                gap = FULLV - m_scale;
                inc = (gap * rt + FULLV - 1) / FULLV;
                m_scale = m_scale + inc;
            end
            if (m_scale > FULLV) m_scale = FULLV;
            if (m_epoch < EMAXV) m_epoch++;
        end
        @(negedge clk);
        check_all();
    endtask

    initial begin
        #2000000;
        bad++; total++;
        $display("FAIL watchdog: run hung, expected completion");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        tag = "R1"; check_all();
        rst_n = 1'b1;
        @(negedge clk); check_all();
        step(1, 0, 0, 0, "R2");
        // exponential, tau about 40
        for (int i = 0; i < 60; i++) step(0, 1, 0, 1638, "R3");
        for (int i = 0; i < 5; i++)  step(0, 0, 0, 1638, "R5");
        step(0, 1, 0, 0, "R8");
        step(0, 1, 0, 0, "R8");
        // restart coinciding with a tick
        step(1, 1, 0, 1638, "R2");
        // exponential, tau about 35, interleaved idle cycles
        for (int i = 0; i < 40; i++) begin
            step(0, 1, 0, 1872, "R3");
            step(0, 0, 1, 9999, "R5");
        end
        // fast exponential to reach full scale through 1-LSB steps
        step(1, 0, 0, 0, "R2");
        for (int i = 0; i < 80; i++) step(0, 1, 0, 40000, "R6");
        for (int i = 0; i < 4; i++) step(0, 1, 1, 500, "R6");
        // linear ramp to saturation
        step(1, 0, 1, 0, "R2");
        for (int i = 0; i < 70; i++) step(0, 1, 1, 1000, "R4");
        // mode switch mid-run
        step(1, 0, 0, 0, "R2");
        for (int i = 0; i < 10; i++) step(0, 1, 1, 3000, "R4");
        for (int i = 0; i < 10; i++) step(0, 1, 0, 5000, "R3");
        // epoch saturation
        for (int i = 0; i < 300; i++) step(0, 1, 0, 100, "R7");
        step(0, 0, 0, 100, "R5");
        step(1, 1, 1, 100, "R2");
        step(0, 1, 1, 0, "R8");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule